// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as seven packed-BCD registers: seconds, minutes, hours, day of week, day of month, month and a two-digit year that stands for 2000 to 2099. Each accepted one-second pulse advances the seconds field. Carries then ripple through minutes, hours, weekday, day of month, month and year, following each month's length and the leap-year rule for February.

The hour register can count in one of two forms, chosen by the hour register itself. In 24-hour form it counts 00 to 23. In 12-hour form it counts 1 to 12 and carries an AM/PM flag. Software reaches the registers through a synchronous write port and a registered read port. A stop input freezes the count, standing in for a disabled oscillator. A one-cycle tick marks every second that is actually taken, so that alarm-compare logic can sample a freshly updated time.

Top module: `rtcc_clock`

## Requirements
- R1: After reset the registers read seconds 0x00, minutes 0x00, hours 0x00 (24-hour form), weekday 0x01, day 0x01, month 0x01 and year 0x00, and `sec_tick_o` is low.
- R2: `rd_data_o` presents, one clock after `rd_addr_i` is set, the register at that address. The addresses are seconds 0, minutes 1, hours 2, weekday 3, day 4, month 5 and year 6; address 7 reads 0x00. Unused bits read as zero: bit 7 of seconds, minutes and hours; bits 7:3 of weekday; bits 7:6 of day; bits 7:5 of month.
- R3: Seconds count 0x00 to 0x59 in BCD and wrap to 0x00 with a carry into minutes. Minutes do the same and carry into hours.
- R4: With hour bit 6 clear (24-hour form), hours count 0x00 to 0x23; 0x23 wraps to 0x00 and carries into the day.
- R5: With hour bit 6 set (12-hour form), bits 4:0 hold 1 to 12 in BCD and bit 5 is PM. Going from 11 to 12 toggles PM. Going from 12 to 01 leaves PM unchanged. Only 11 PM rolling to 12 AM carries into the day.
- R6: The weekday counts 1 to 7, steps on each day carry, and wraps from 7 to 1.
- R7: The day of month wraps to 0x01 after day 30 in April, June, September and November, and after day 31 in the other months except February; each wrap carries into the month.
- R8: February wraps after day 0x29 when the year value is divisible by 4, and after 0x28 otherwise.
- R9: Month 0x12 wraps to 0x01 with a carry into the year; year 0x99 wraps to 0x00.
- R10: While `osc_stop_i` is high, `sec_pulse_i` is ignored, the time holds and no tick appears.
- R11: A write stores `wr_data_i`, with the unused bits masked off, into the addressed register on the next clock edge. A second pulse that arrives in a write cycle is held and applied in the first cycle without a write, starting from the written value.
- R12: `sec_tick_o` is high for exactly one cycle after each applied advance, in the cycle when the advanced values are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_pulse_i | input | 1 | One-cycle pulse per second |
| osc_stop_i | input | 1 | High freezes the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data (BCD) |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | 8 | Registered read data |
| sec_tick_o | output | 1 | High one cycle after each applied second |

## Verification
The bench drives the carry chain through its edges: 59→00 in the low fields, 23→00 in 24-hour form, and 11→12 and 12→01 in 12-hour form. It also covers 30- and 31-day months, February in leap and common years, and the turn of the century. A design with a wrong PM toggle reports 12 with the old half of the day or carries the date at noon. A design with a wrong month table stops one day early or late. Further cases check that a held-off pulse in a write cycle is taken from the written value rather than lost, that stop freezes time, and that unused bits read zero. A design that loses the held pulse shows a stale seconds value.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  localparam int NUM_REGS = 7;
  localparam int DATA_W   = 8;

  localparam int RA_SEC  = 0;
  localparam int RA_MIN  = 1;
  localparam int RA_HOUR = 2;
  localparam int RA_WDAY = 3;
  localparam int RA_MDAY = 4;
  localparam int RA_MON  = 5;
  localparam int RA_YEAR = 6;

  localparam logic [7:0] MSK_SEC  = 8'h7F;
  localparam logic [7:0] MSK_MIN  = 8'h7F;
  localparam logic [7:0] MSK_HOUR = 8'h7F;
  localparam logic [7:0] MSK_WDAY = 8'h07;
  localparam logic [7:0] MSK_MDAY = 8'h3F;
  localparam logic [7:0] MSK_MON  = 8'h1F;
  localparam logic [7:0] MSK_YEAR = 8'hFF;

  // add one to a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'h0, y[7:4]} << 3) + ({4'h0, y[7:4]} << 1) + {4'h0, y[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // last day of a BCD month
  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    logic [7:0] d;
    case (m)
      8'h02:                      d = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtcc_hms.sv
module rtcc_hms
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic [7:0] wdata,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);

  logic       sec_wrap, min_wrap, min_step, hr_step;
  logic [7:0] sec_nx, min_nx, hour_nx;
  logic       hr_day;

  always_comb begin
    sec_wrap = (sec_q >= 8'h59);
    sec_nx   = sec_wrap ? 8'h00 : bcd_inc(sec_q);
    min_wrap = (min_q >= 8'h59);
    min_nx   = min_wrap ? 8'h00 : bcd_inc(min_q);
    min_step = step & sec_wrap;
    hr_step  = min_step & min_wrap;
  end

  always_comb begin
    logic [7:0] f12, f24, inc12;
    logic       pm;
    f12   = {3'b000, hour_q[4:0]};
    f24   = {2'b00, hour_q[5:0]};
    pm    = hour_q[5];
    inc12 = bcd_inc(f12);
    hour_nx = 8'h00;
    hr_day  = 1'b0;
    if (hour_q[6]) begin
      if (f12 >= 8'h12) begin
        hour_nx = {1'b0, 1'b1, pm, 5'h01};
      end else if (f12 == 8'h11) begin
        hour_nx = {1'b0, 1'b1, ~pm, 5'h12};
        hr_day  = pm;
      end else begin
        hour_nx = {1'b0, 1'b1, pm, inc12[4:0]};
      end
    end else begin
      if (f24 >= 8'h23) begin
        hour_nx = 8'h00;
        hr_day  = 1'b1;
      end else begin
        hour_nx = bcd_inc(f24);
      end
    end
  end

  assign day_carry = hr_step & hr_day;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_sec)        sec_q <= wdata & MSK_SEC;
      else if (step)     sec_q <= sec_nx;
      if (wr_min)        min_q <= wdata & MSK_MIN;
      else if (min_step) min_q <= min_nx;
      if (wr_hour)       hour_q <= wdata & MSK_HOUR;
      else if (hr_step)  hour_q <= hour_nx;
    end
  end

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    step && !wr_sec && sec_q == 8'h59 |=> sec_q == 8'h00);

  // R5
  pm_flip_chk: assert property (@(posedge clk) disable iff (rst)
    hr_step && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h11
    |=> hour_q[4:0] == 5'h12 && hour_q[5] != $past(hour_q[5]));

  // R5
  noon_one_chk: assert property (@(posedge clk) disable iff (rst)
    hr_step && !wr_hour && hour_q[6] && hour_q[4:0] == 5'h12
    |=> hour_q[4:0] == 5'h01 && $stable(hour_q[5]));

  // R10
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step && !wr_sec |=> $stable(sec_q));

endmodule

// File: rtl/rtcc_date.sv
module rtcc_date
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       day_step,
  input  logic       wr_wday,
  input  logic       wr_mday,
  input  logic       wr_mon,
  input  logic       wr_year,
  input  logic [7:0] wdata,
  output logic [7:0] wday_q,
  output logic [7:0] mday_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q
);

  logic [7:0] last_day;
  logic       mday_wrap, mon_wrap, mon_step, yr_step;
  logic [7:0] wday_nx, mday_nx, mon_nx, year_nx;

  always_comb begin
    last_day  = month_last(mon_q, leap_year(year_q));
    mday_wrap = (mday_q >= last_day);
    mon_wrap  = (mon_q >= 8'h12);
    mon_step  = day_step & mday_wrap;
    yr_step   = mon_step & mon_wrap;
    wday_nx   = (wday_q >= 8'h07) ? 8'h01 : wday_q + 8'h01;
    mday_nx   = mday_wrap ? 8'h01 : bcd_inc(mday_q);
    mon_nx    = mon_wrap ? 8'h01 : bcd_inc(mon_q);
    year_nx   = (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wday_q <= 8'h01;
      mday_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      if (wr_wday)        wday_q <= wdata & MSK_WDAY;
      else if (day_step)  wday_q <= wday_nx;
      if (wr_mday)        mday_q <= wdata & MSK_MDAY;
      else if (day_step)  mday_q <= mday_nx;
      if (wr_mon)         mon_q <= wdata & MSK_MON;
      else if (mon_step)  mon_q <= mon_nx;
      if (wr_year)        year_q <= wdata & MSK_YEAR;
      else if (yr_step)   year_q <= year_nx;
    end
  end

  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    day_step && !wr_wday && wday_q == 8'h07 |=> wday_q == 8'h01);

  // R8
  leap_feb_chk: assert property (@(posedge clk) disable iff (rst)
    day_step && !wr_mday && mon_q == 8'h02 && mday_q == 8'h28 && leap_year(year_q)
    |=> mday_q == 8'h29);

  // R9
  year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    day_step && !wr_year && !wr_mon && !wr_mday && year_q == 8'h99 &&
    mon_q == 8'h12 && mday_q == 8'h31 |=> year_q == 8'h00 && mon_q == 8'h01);

endmodule

// File: rtl/rtcc_clock.sv
module rtcc_clock
  import rtcc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_pulse_i,
  input  logic              osc_stop_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              sec_tick_o
);

  logic [NUM_REGS-1:0] wr_sel;
  logic                pend_q, tick_req, adv, day_carry;
  logic [7:0]          regs_v [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
  end

  assign tick_req = (sec_pulse_i & ~osc_stop_i) | pend_q;
  assign adv      = tick_req & ~wr_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      sec_tick_o <= 1'b0;
    end else begin
      pend_q     <= tick_req & wr_en_i;
      sec_tick_o <= adv;
    end
  end

  rtcc_hms u_hms (
    .clk       (clk),
    .rst       (rst),
    .step      (adv),
    .wr_sec    (wr_sel[RA_SEC]),
    .wr_min    (wr_sel[RA_MIN]),
    .wr_hour   (wr_sel[RA_HOUR]),
    .wdata     (wr_data_i),
    .sec_q     (regs_v[RA_SEC]),
    .min_q     (regs_v[RA_MIN]),
    .hour_q    (regs_v[RA_HOUR]),
    .day_carry (day_carry)
  );

  rtcc_date u_date (
    .clk      (clk),
    .rst      (rst),
    .day_step (day_carry),
    .wr_wday  (wr_sel[RA_WDAY]),
    .wr_mday  (wr_sel[RA_MDAY]),
    .wr_mon   (wr_sel[RA_MON]),
    .wr_year  (wr_sel[RA_YEAR]),
    .wdata    (wr_data_i),
    .wday_q   (regs_v[RA_WDAY]),
    .mday_q   (regs_v[RA_MDAY]),
    .mon_q    (regs_v[RA_MON]),
    .year_q   (regs_v[RA_YEAR])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= 8'h00;
    end else begin
      rd_data_o <= 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (rd_addr_i == ADDR_W'(i)) rd_data_o <= regs_v[i];
      end
    end
  end

  // R11
  defer_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sec_pulse_i && !osc_stop_i) ##1 !wr_en_i |=> sec_tick_o);

  // R12
  tick_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> !sec_tick_o);

endmodule

// File: tb/rtcc_clock_tb.sv
module rtcc_clock_tb_top;

  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sec_pulse = 1'b0;
  logic          osc_stop = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = 8'h00;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          sec_tick;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtcc_clock #(.ADDR_W(AW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .sec_pulse_i(sec_pulse),
    .osc_stop_i (osc_stop),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .sec_tick_o (sec_tick)
  );

  // monitor: compares read data against expected items as they fall due
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%02h expected=%02h", it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic read_exp(input int a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_addr = AW'(a);
    it.due = cyc + 1;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, wd, md, mo, yr);
    wr(0, s); wr(1, m); wr(2, h); wr(3, wd); wr(4, md); wr(5, mo); wr(6, yr);
  endtask

  task automatic pulse(input logic exp_tick, input string tag);
    @(negedge clk);
    sec_pulse = 1'b1;
    @(negedge clk);
    sec_pulse = 1'b0;
    chk(tag, {7'b0, sec_tick}, {7'b0, exp_tick});
  endtask

  task automatic read_all(input logic [7:0] s, m, h, wd, md, mo, yr, input string tag);
    read_exp(0, s, tag); read_exp(1, m, tag); read_exp(2, h, tag);
    read_exp(3, wd, tag); read_exp(4, md, tag); read_exp(5, mo, tag);
    read_exp(6, yr, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 tick", {7'b0, sec_tick}, 8'h00);
    read_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset");
    // R2 empty address
    read_exp(7, 8'h00, "R2 addr7");

    // R3 seconds and minutes
    wr(0, 8'h58);
    pulse(1'b1, "R12 tick");
    read_exp(0, 8'h59, "R3 sec inc");
    pulse(1'b1, "R12 tick");
    read_exp(0, 8'h00, "R3 sec wrap");
    read_exp(1, 8'h01, "R3 min carry");
    set_time(8'h59, 8'h59, 8'h05, 8'h02, 8'h01, 8'h01, 8'h00);
    pulse(1'b1, "R12 tick");
    read_all(8'h00, 8'h00, 8'h06, 8'h02, 8'h01, 8'h01, 8'h00, "R3 hour carry");

    // R4 24h midnight, R6 weekday wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h10);
    pulse(1'b1, "R12 tick");
    read_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h03, 8'h10, "R4 R6 midnight");

    // R5 12h form
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h10, 8'h01, 8'h10);
    pulse(1'b1, "R12 tick");
    read_exp(2, 8'h72, "R5 11AM to 12PM");
    read_exp(4, 8'h10, "R5 no day carry at noon");
    wr(1, 8'h59); wr(0, 8'h59);
    pulse(1'b1, "R12 tick");
    read_exp(2, 8'h61, "R5 12PM to 1PM");
    wr(2, 8'h71); wr(1, 8'h59); wr(0, 8'h59);
    pulse(1'b1, "R12 tick");
    read_exp(2, 8'h52, "R5 11PM to 12AM");
    read_exp(3, 8'h04, "R5 R6 wday step");
    read_exp(4, 8'h11, "R5 day carry");

    // R7 month lengths
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    pulse(1'b1, "R12 tick");
    read_exp(4, 8'h01, "R7 april end");
    read_exp(5, 8'h05, "R7 april carry");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h05, 8'h10);
    pulse(1'b1, "R12 tick");
    read_exp(4, 8'h31, "R7 may 31");

    // R8 February
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    pulse(1'b1, "R12 tick");
    read_exp(4, 8'h29, "R8 leap 29");
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    pulse(1'b1, "R12 tick");
    read_exp(4, 8'h01, "R8 leap end");
    read_exp(5, 8'h03, "R8 leap march");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    pulse(1'b1, "R12 tick");
    read_exp(4, 8'h01, "R8 common end");
    read_exp(5, 8'h03, "R8 common march");

    // R9 century wrap
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
    pulse(1'b1, "R12 tick");
    read_all(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, "R9 year wrap");

    // R10 stop
    wr(0, 8'h20);
    osc_stop = 1'b1;
    pulse(1'b0, "R10 no tick");
    pulse(1'b0, "R10 no tick");
    read_exp(0, 8'h20, "R10 held");
    osc_stop = 1'b0;

    // R11 write collides with a pulse
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10; sec_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; sec_pulse = 1'b0;
    chk("R11 no tick in write", {7'b0, sec_tick}, 8'h00);
    @(negedge clk);
    chk("R11 deferred tick", {7'b0, sec_tick}, 8'h01);
    @(negedge clk);
    chk("R12 single cycle", {7'b0, sec_tick}, 8'h00);
    read_exp(0, 8'h11, "R11 deferred from written");

    // R2 R11 masking
    wr(3, 8'hFF);
    read_exp(3, 8'h07, "R2 wday mask");
    wr(5, 8'hFF);
    read_exp(5, 8'h1F, "R2 month mask");
    wr(0, 8'hD9);
    read_exp(0, 8'h59, "R2 sec mask");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule